// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns one multi-register transfer command into a stream of per-register beats. A command carries a base address, a 16-bit register mask, a two-bit addressing mode and a write-back flag. The block issues one beat for each set bit of the mask. Each beat carries the register index and the word address for that register. Beats are issued in ascending register order, and the addresses rise by one word per beat whatever direction the mode points. The mode only decides where the window of words starts and where the base ends up. This lets the same sequencer serve ascending and descending stacks, and both the full and the empty pointer conventions.

Both the command input and the beat output use valid/ready. A command is taken only in a cycle where `cmd_valid_i` and `cmd_ready_o` are both high, and `cmd_ready_o` stays low until the current command has completed. A beat moves only in a cycle where `beat_valid_o` and `beat_ready_i` are both high. While the consumer holds `beat_ready_i` low, the beat on the output stays frozen. Completion is a plain one-cycle pulse on `done_o`, which comes with the updated base and the write-back flag. The memory side and the register file sit outside this block.

Top module: `blkxfer_addr_seq`

## Requirements
- R1: After reset, `cmd_ready_o` is 1, and `beat_valid_o` and `done_o` are 0.
- R2: A command is accepted on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both 1. From the next cycle, `cmd_ready_o` is 0 until the completion pulse has ended, and `cmd_ready_o` is never 1 while `beat_valid_o` or `done_o` is 1.
- R3: With n set bits in the mask and A the aligned base, the first beat address depends on `cmd_mode_i` as follows:
  - 0 (ascending, step after): A
  - 1 (ascending, step before): A+4
  - 2 (descending, step after): A−4n+4
  - 3 (descending, step before): A−4n
- R4: Beats carry the indices of the set mask bits in strictly ascending order, one beat per handshake. Each beat's address is the previous beat's address plus 4.
- R5: While `beat_valid_o` is 1 and `beat_ready_i` is 0, the beat index, address and last flag hold their values in the next cycle.
- R6: `beat_last_o` is 1 on the final beat of a command and 0 on every other beat.
- R7: In the cycle after the final beat's handshake, `done_o` is 1 for exactly one cycle and `beat_valid_o` is 0. At the same time `done_wb_o` equals the command's write-back flag, and `done_base_o` is:
  - A+4n for modes 0 and 1 when write-back is 1;
  - A−4n for modes 2 and 3 when write-back is 1;
  - A when write-back is 0.
- R8: A command with an all-zero mask issues no beat. `done_o` rises in the cycle right after acceptance, with `done_base_o` equal to A.
- R9: The aligned base A is `cmd_base_i` with bits 1:0 cleared. Bits 1:0 of `beat_addr_o` and of `done_base_o` are always 0.
- R10: `cmd_ready_o` is 1 again in the cycle after the completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Sequencer idle and able to take a command |
| cmd_base_i | input | 32 | Base address of the transfer |
| cmd_list_i | input | 16 | Register mask, bit i selects register i |
| cmd_mode_i | input | 2 | Addressing mode, encoding as in R3 |
| cmd_wb_i | input | 1 | Write-back request for the base |
| beat_valid_o | output | 1 | A beat is presented |
| beat_ready_i | input | 1 | Consumer takes the beat |
| beat_idx_o | output | 4 | Register index of the beat |
| beat_addr_o | output | 32 | Word address of the beat |
| beat_last_o | output | 1 | Final beat of the command |
| done_o | output | 1 | One-cycle completion pulse |
| done_wb_o | output | 1 | Write-back flag of the completed command |
| done_base_o | output | 32 | Base value to write back, per R7 |

## Verification
The bench goes after these corner cases:
- Empty masks in every mode. A design that mishandles them would emit a spurious beat or never raise `done_o`.
- The full 16-bit mask and a lone register 15 in the descending modes. Miscounting n here moves the whole window by one word.
- A base near zero with the descending modes. Here the address must wrap modulo 2^32 and not saturate.
- Unaligned bases, which must be truncated to a word before any offset is applied.
- Heavy back-pressure. A sequencer that advances without a handshake would skip registers or change the address under a stalled beat.
- Write-back cleared. A design that got this wrong would report the moved base instead of the original one.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  // Addressing mode; bit 1 selects descending, bit 0 selects step-before.
  typedef enum logic [1:0] {
    XFER_INC_AFTER  = 2'd0,
    XFER_INC_BEFORE = 2'd1,
    XFER_DEC_AFTER  = 2'd2,
    XFER_DEC_BEFORE = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_DONE  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/blkxfer_plan.sv
// Works out the window of a transfer from the command: the register count,
// the first beat address and the final base value.
module blkxfer_plan
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIST_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LIST_W-1:0] list_i,
  input  xfer_mode_e        mode_i,
  output logic [ADDR_W-1:0] start_o,
  output logic [ADDR_W-1:0] end_o
);
  localparam int CNT_W   = $clog2(LIST_W + 1);
  localparam int WORD_SH = 2;
  localparam logic [ADDR_W-1:0] WORD = ADDR_W'(1) << WORD_SH;

  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] span;

  always_comb begin
    count = '0;
    for (int i = 0; i < LIST_W; i++) begin
      count = count + CNT_W'(list_i[i]);
    end
  end

  assign span = ADDR_W'(count) << WORD_SH;

  always_comb begin
    unique case (mode_i)
      XFER_INC_AFTER:  start_o = base_i;
      XFER_INC_BEFORE: start_o = base_i + WORD;
      XFER_DEC_AFTER:  start_o = base_i - span + WORD;
      default:         start_o = base_i - span;
    endcase
  end

  assign end_o = mode_i[1] ? (base_i - span) : (base_i + span);

endmodule

// File: rtl/blkxfer_pick.sv
// Finds the lowest set bit of the remaining mask and whether it is the only one.
module blkxfer_pick #(
  parameter int LIST_W = 16
) (
  input  logic [LIST_W-1:0]         list_i,
  output logic [LIST_W-1:0]         onehot_o,
  output logic [$clog2(LIST_W)-1:0] idx_o,
  output logic                      single_o
);
  localparam int IDX_W = $clog2(LIST_W);

  logic [LIST_W-1:0] below;

  assign below[0] = 1'b0;
  for (genvar gi = 1; gi < LIST_W; gi++) begin : g_below
    assign below[gi] = below[gi-1] | list_i[gi-1];
  end

  assign onehot_o = list_i & ~below;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < LIST_W; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  assign single_o = (list_i != '0) && ((list_i & (list_i - 1'b1)) == '0);

endmodule

// File: rtl/blkxfer_addr_seq.sv
module blkxfer_addr_seq
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIST_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid_i,
  output logic                      cmd_ready_o,
  input  logic [ADDR_W-1:0]         cmd_base_i,
  input  logic [LIST_W-1:0]         cmd_list_i,
  input  logic [1:0]                cmd_mode_i,
  input  logic                      cmd_wb_i,
  output logic                      beat_valid_o,
  input  logic                      beat_ready_i,
  output logic [$clog2(LIST_W)-1:0] beat_idx_o,
  output logic [ADDR_W-1:0]         beat_addr_o,
  output logic                      beat_last_o,
  output logic                      done_o,
  output logic                      done_wb_o,
  output logic [ADDR_W-1:0]         done_base_o
);
  localparam int IDX_W = $clog2(LIST_W);
  localparam logic [ADDR_W-1:0] WORD = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

  seq_state_e        state_q;
  logic [LIST_W-1:0] rem_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] base_q;
  logic              wb_q;

  logic [ADDR_W-1:0] base_al;
  logic [ADDR_W-1:0] plan_start;
  logic [ADDR_W-1:0] plan_end;
  logic [LIST_W-1:0] pick_onehot;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_single;
  logic              cmd_take;
  logic              beat_take;

  assign base_al = cmd_base_i & ALIGN_MASK;

  blkxfer_plan #(.ADDR_W(ADDR_W), .LIST_W(LIST_W)) u_plan (
    .base_i  (base_al),
    .list_i  (cmd_list_i),
    .mode_i  (xfer_mode_e'(cmd_mode_i)),
    .start_o (plan_start),
    .end_o   (plan_end)
  );

  blkxfer_pick #(.LIST_W(LIST_W)) u_pick (
    .list_i   (rem_q),
    .onehot_o (pick_onehot),
    .idx_o    (pick_idx),
    .single_o (pick_single)
  );

  assign cmd_ready_o  = (state_q == SQ_IDLE);
  assign beat_valid_o = (state_q == SQ_ISSUE);
  assign done_o       = (state_q == SQ_DONE);
  assign cmd_take     = cmd_valid_i && cmd_ready_o;
  assign beat_take    = beat_valid_o && beat_ready_i;

  assign beat_idx_o  = pick_idx;
  assign beat_addr_o = addr_q;
  assign beat_last_o = pick_single;
  assign done_wb_o   = wb_q;
  assign done_base_o = base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      base_q  <= '0;
      wb_q    <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (cmd_take) begin
            rem_q   <= cmd_list_i;
            addr_q  <= plan_start;
            base_q  <= cmd_wb_i ? plan_end : base_al;
            wb_q    <= cmd_wb_i;
            state_q <= (cmd_list_i == '0) ? SQ_DONE : SQ_ISSUE;
          end
        end
        SQ_ISSUE: begin
          if (beat_take) begin
            rem_q  <= rem_q & ~pick_onehot;
            addr_q <= addr_q + WORD;
            if (pick_single) state_q <= SQ_DONE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/blkxfer_chk.sv
module blkxfer_chk #(
  parameter int ADDR_W = 32,
  parameter int LIST_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cmd_ready,
  input logic                      beat_valid,
  input logic                      beat_ready,
  input logic [$clog2(LIST_W)-1:0] beat_idx,
  input logic [ADDR_W-1:0]         beat_addr,
  input logic                      beat_last,
  input logic                      done,
  input logic [ADDR_W-1:0]         done_base
);

  assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && (beat_valid || done)));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && !beat_last |=>
      beat_valid && (beat_addr == $past(beat_addr) + ADDR_W'(4)) &&
      (beat_idx > $past(beat_idx)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=>
      beat_valid && $stable(beat_addr) && $stable(beat_idx) && $stable(beat_last));

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_last |=> done && !beat_valid);

  assert_beat_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_addr[1:0] == 2'b00));

  assert_base_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_base[1:0] == 2'b00));

  assert_done_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && cmd_ready);

endmodule

bind blkxfer_addr_seq blkxfer_chk #(.ADDR_W(ADDR_W), .LIST_W(LIST_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_ready  (cmd_ready_o),
  .beat_valid (beat_valid_o),
  .beat_ready (beat_ready_i),
  .beat_idx   (beat_idx_o),
  .beat_addr  (beat_addr_o),
  .beat_last  (beat_last_o),
  .done       (done_o),
  .done_base  (done_base_o)
);

// File: tb/test_blkxfer_addr_seq.sv
module test_blkxfer_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_base = '0;
  logic [15:0] cmd_list = '0;
  logic [1:0]  cmd_mode = '0;
  logic        cmd_wb = 1'b0;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic [3:0]  beat_idx;
  logic [31:0] beat_addr;
  logic        beat_last;
  logic        done;
  logic        done_wb;
  logic [31:0] done_base;

  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;  // 50 MHz

  blkxfer_addr_seq i_blkxfer_addr_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_base_i(cmd_base), .cmd_list_i(cmd_list), .cmd_mode_i(cmd_mode), .cmd_wb_i(cmd_wb),
    .beat_valid_o(beat_valid), .beat_ready_i(beat_ready),
    .beat_idx_o(beat_idx), .beat_addr_o(beat_addr), .beat_last_o(beat_last),
    .done_o(done), .done_wb_o(done_wb), .done_base_o(done_base)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_start(input logic [31:0] a, input int n, input logic [1:0] m);
    case (m)
      2'd0:    return a;
      2'd1:    return a + 32'd4;
      2'd2:    return a - 32'(4 * n) + 32'd4;
      default: return a - 32'(4 * n);
    endcase
  endfunction

  function automatic logic [31:0] exp_end(input logic [31:0] a, input int n, input logic [1:0] m, input logic w);
    if (!w) return a;
    return m[1] ? a - 32'(4 * n) : a + 32'(4 * n);
  endfunction

  // Starts and ends just after a falling edge.
  task automatic run_cmd(input logic [31:0] b, input logic [15:0] l, input logic [1:0] m,
                         input logic w, input int rdy_pct);
    logic [31:0] al, a;
    int n, k;
    al = b & ~32'h3;
    n  = $countones(l);
    a  = exp_start(al, n, m);
    check(cmd_ready == 1'b1, "R2 ready before command", 32'(cmd_ready), 32'd1);
    cmd_valid = 1'b1; cmd_base = b; cmd_list = l; cmd_mode = m; cmd_wb = w;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; cmd_base = $urandom; cmd_list = 16'(~l); cmd_mode = ~m;
    check(cmd_ready == 1'b0, "R2 busy after acceptance", 32'(cmd_ready), 32'd0);
    if (n == 0) begin
      check(done == 1'b1, "R8 empty list done", 32'(done), 32'd1);
      check(beat_valid == 1'b0, "R8 empty list no beat", 32'(beat_valid), 32'd0);
      check(done_base == al, "R8 empty list base", done_base, al);
    end else begin
      k = 0;
      for (int i = 0; i < 16; i++) begin
        if (l[i]) begin
          int stalls;
          logic hs;
          stalls = 0;
          hs = 1'b0;
          while (!hs) begin
            check(beat_valid == 1'b1, "R4 beat valid", 32'(beat_valid), 32'd1);
            check(beat_idx == 4'(i), "R4 beat index", 32'(beat_idx), 32'(i));
            check(beat_addr == a, "R3 R4 R9 beat address", beat_addr, a);
            check(beat_last == (k == n - 1), "R6 last flag", 32'(beat_last), 32'(k == n - 1));
            beat_ready = (stalls > 6) || (($urandom % 100) < 32'(rdy_pct));
            if (!beat_ready) stalls++;  // R5: next pass rechecks the frozen beat
            @(posedge clk);
            hs = beat_ready;
            @(negedge clk);
          end
          a = a + 32'd4;
          k++;
        end
      end
      beat_ready = 1'b0;
      check(done == 1'b1, "R7 done after last beat", 32'(done), 32'd1);
      check(beat_valid == 1'b0, "R7 no beat at done", 32'(beat_valid), 32'd0);
      check(done_base == exp_end(al, n, m, w), "R7 final base", done_base, exp_end(al, n, m, w));
      check(done_wb == w, "R7 write-back flag", 32'(done_wb), 32'(w));
    end
    @(negedge clk);
    check(done == 1'b0, "R10 single done pulse", 32'(done), 32'd0);
    check(cmd_ready == 1'b1, "R10 ready after done", 32'(cmd_ready), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(cmd_ready == 1'b1, "R1 reset ready", 32'(cmd_ready), 32'd1);
    check(beat_valid == 1'b0, "R1 reset beat", 32'(beat_valid), 32'd0);
    check(done == 1'b0, "R1 reset done", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1 idle after reset", 32'(cmd_ready), 32'd1);

    // R8 empty mask in every mode
    for (int m = 0; m < 4; m++) run_cmd(32'h0000_1000, 16'h0000, 2'(m), 1'b1, 100);
    // R3 R7 three-register example in every mode
    for (int m = 0; m < 4; m++) run_cmd(32'h0000_0200, 16'h0013, 2'(m), 1'b1, 60);
    // R3 full mask, descending, heavy back-pressure (R5)
    run_cmd(32'h0000_8000, 16'hFFFF, 2'd3, 1'b1, 20);
    run_cmd(32'h0000_8000, 16'hFFFF, 2'd2, 1'b1, 20);
    // lone top register
    run_cmd(32'h0000_0400, 16'h8000, 2'd3, 1'b1, 100);
    run_cmd(32'h0000_0400, 16'h8000, 2'd1, 1'b1, 100);
    // R9 unaligned base; wrap below zero
    run_cmd(32'h0000_0107, 16'h0101, 2'd0, 1'b1, 100);
    run_cmd(32'h0000_0004, 16'h00F0, 2'd3, 1'b1, 70);
    // R7 write-back cleared
    run_cmd(32'h1234_5678, 16'h0A0A, 2'd2, 1'b0, 70);

    for (int t = 0; t < 300; t++) begin
      logic [15:0] l;
      l = 16'($urandom);
      if (($urandom % 8) == 0) l = l & 16'($urandom) & 16'($urandom);
      run_cmd($urandom, l, 2'($urandom), 1'($urandom), 30 + int'($urandom % 71));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule